// File: doc/BRIEF.md
# Memory Scrub Sequencer with Hazard Hold

This block writes corrected data back to memory after a read whose ECC check found an error. Error reports come from two sources: demand reads and a background patrol engine. Each report carries the byte address, the corrected 32-byte payload and its recomputed 4-byte ECC. Every report is logged. A correctable report that arrives while the sequencer is idle starts a scrub. The scrub issues one write command that carries the payload and the ECC together, with the address aligned to the 32-byte line. Only one scrub can be in flight at a time.

While a scrub is in flight, the block watches a request-check port for incoming read and write addresses. A request that falls inside the line being scrubbed is held. Requests to any other line pass through.

There are two correction modes, chosen when a scrub is accepted. In normal mode the scrub ends on its first write response, whatever that response is. Enhanced mode is selected when the mode bit is set and the bad-device threshold is non-zero. In enhanced mode a failed write is replayed once. If the replay also fails, the scrub is dropped and the held requests are released.

Top module: `scrub_seq`

## Requirements
- R1: After reset, wr_valid_o, req_hold_o, log_valid_o, log_ovf_o and dropped_o are all 0.
- R2: Each cycle with err_valid_i high produces log_valid_o high on the next cycle. In that cycle log_addr_o, log_src_o and log_corr_o carry the reported address, source (0 = demand, 1 = patrol) and correctable flag. A cycle without a report gives log_valid_o low on the next cycle.
- R3: A correctable report accepted while idle raises wr_valid_o one cycle later. The command carries wr_addr_o (the report address with its low 5 bits cleared), wr_data_o (the payload) and wr_ecc_o (the ECC). All of these stay stable until wr_ready_i is seen.
- R4: A report with err_corr_i low is logged but issues no write.
- R5: A correctable report that arrives while a scrub is in flight issues no extra write. Its log entry has log_ovf_o = 1. log_ovf_o is 0 for every other entry.
- R6: From the cycle after acceptance until the scrub ends, req_hold_o is high in the same cycle as a req_valid_i whose address falls in the scrubbed 32-byte line. Requests to other lines, and any request while idle, give req_hold_o = 0.
- R7: In normal mode (mode_enh_i = 0, or bad_th_i = 0) exactly one write is issued. The scrub ends on the first response, pass or fail. The hold is released in the cycle after the response, and dropped_o stays 0.
- R8: In enhanced mode a response with rsp_ok_i = 0 causes exactly one replay of the same command. wr_valid_o returns in the cycle after that response. A passing replay ends the scrub without dropped_o.
- R9: In enhanced mode a failed replay drops the scrub. dropped_o pulses for one cycle in the cycle after the failing response, the hold is released in that same cycle, and no third write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_enh_i | input | 1 | Correction mode select (1 = enhanced when threshold non-zero) |
| bad_th_i | input | TH_W | Bad-device threshold; zero forces normal mode |
| err_valid_i | input | 1 | Error report strobe |
| err_src_i | input | 1 | Report source: 0 demand, 1 patrol |
| err_corr_i | input | 1 | Error is correctable |
| err_addr_i | input | ADDR_W | Byte address of the failing read |
| err_data_i | input | DATA_W | Corrected 32-byte payload |
| err_ecc_i | input | ECC_W | Recomputed ECC |
| req_valid_i | input | 1 | Incoming read/write request present |
| req_addr_i | input | ADDR_W | Incoming request byte address |
| req_hold_o | output | 1 | Request conflicts with the scrubbed line; hold it |
| wr_valid_o | output | 1 | Scrub write command valid |
| wr_ready_i | input | 1 | Scrub write command accepted |
| wr_addr_o | output | ADDR_W | Line-aligned write address |
| wr_data_o | output | DATA_W | Payload to write back |
| wr_ecc_o | output | ECC_W | ECC to write back |
| rsp_valid_i | input | 1 | Write response strobe |
| rsp_ok_i | input | 1 | Write response: 1 pass, 0 fail |
| log_valid_o | output | 1 | Log entry valid |
| log_addr_o | output | ADDR_W | Logged address |
| log_src_o | output | 1 | Logged source |
| log_corr_o | output | 1 | Logged correctable flag |
| log_ovf_o | output | 1 | Correctable error not scrubbed because busy |
| dropped_o | output | 1 | One-cycle pulse: scrub dropped after failed replay |

## Verification
The assertions check several rules on every cycle: the one-cycle relation between a report and its log entry, the stability of a write command that has not yet been accepted, that overflow is flagged only on correctable entries, that a hold appears only alongside a request, and that a drop pulse always follows a failing response. Only the bench scenarios can show the rest. That covers how many writes each mode and response pattern produces, whether a hold applies to the correct line, the exact cycle the hold is released, and the absence of a third attempt after a drop.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int unsigned LINE_BYTES = 32;
  localparam int unsigned OFS_W      = $clog2(LINE_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } scrub_state_e;
endpackage

// File: rtl/scrub_hazard.sv
module scrub_hazard #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 5
) (
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              hold_o
);
  logic match;

  generate
    if (OFS_W == 0) begin : g_full
      assign match = (line_addr_i == req_addr_i);
    end else begin : g_line
      assign match = (line_addr_i[ADDR_W-1:OFS_W] == req_addr_i[ADDR_W-1:OFS_W]);
    end
  endgenerate

  assign hold_o = req_valid_i & busy_i & match;
endmodule

// File: rtl/scrub_log.sv
module scrub_log #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic              err_src_i,
  input  logic              err_corr_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              busy_i,
  output logic              log_valid_o,
  output logic [ADDR_W-1:0] log_addr_o,
  output logic              log_src_o,
  output logic              log_corr_o,
  output logic              log_ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      log_valid_o <= 1'b0;
      log_addr_o  <= '0;
      log_src_o   <= 1'b0;
      log_corr_o  <= 1'b0;
      log_ovf_o   <= 1'b0;
    end else begin
      log_valid_o <= err_valid_i;
      log_ovf_o   <= err_valid_i & err_corr_i & busy_i;
      if (err_valid_i) begin
        log_addr_o <= err_addr_i;
        log_src_o  <= err_src_i;
        log_corr_o <= err_corr_i;
      end
    end
  end
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 256,
  parameter int unsigned ECC_W  = 32,
  parameter int unsigned TH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_enh_i,
  input  logic [TH_W-1:0]   bad_th_i,
  input  logic              err_valid_i,
  input  logic              err_corr_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic [ECC_W-1:0]  err_ecc_i,
  output logic              busy_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ECC_W-1:0]  wr_ecc_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_ok_i,
  output logic              dropped_o
);
  scrub_state_e state_q, state_d;
  logic         enh_q, retried_q;
  logic         accept, rsp_fail, do_retry, do_drop;

  assign accept   = (state_q == ST_IDLE) & err_valid_i & err_corr_i;
  assign rsp_fail = (state_q == ST_WAIT) & rsp_valid_i & ~rsp_ok_i;
  assign do_retry = rsp_fail & enh_q & ~retried_q;
  assign do_drop  = rsp_fail & enh_q & retried_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ISSUE;
      ST_ISSUE: if (wr_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid_i) state_d = do_retry ? ST_ISSUE : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      enh_q     <= 1'b0;
      retried_q <= 1'b0;
      dropped_o <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_ecc_o  <= '0;
    end else begin
      state_q   <= state_d;
      dropped_o <= do_drop;
      if (accept) begin
        // mode is latched per scrub
        enh_q     <= mode_enh_i & (bad_th_i != '0);
        retried_q <= 1'b0;
        wr_addr_o <= {err_addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        wr_data_o <= err_data_i;
        wr_ecc_o  <= err_ecc_i;
      end else if (do_retry) begin
        retried_q <= 1'b1;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign wr_valid_o = (state_q == ST_ISSUE);
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8 * LINE_BYTES,
  parameter int unsigned ECC_W  = 32,
  parameter int unsigned TH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_enh_i,
  input  logic [TH_W-1:0]   bad_th_i,
  input  logic              err_valid_i,
  input  logic              err_src_i,
  input  logic              err_corr_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic [ECC_W-1:0]  err_ecc_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_hold_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ECC_W-1:0]  wr_ecc_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_ok_i,
  output logic              log_valid_o,
  output logic [ADDR_W-1:0] log_addr_o,
  output logic              log_src_o,
  output logic              log_corr_o,
  output logic              log_ovf_o,
  output logic              dropped_o
);
  logic busy;

  scrub_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ECC_W(ECC_W), .TH_W(TH_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_enh_i  (mode_enh_i),
    .bad_th_i    (bad_th_i),
    .err_valid_i (err_valid_i),
    .err_corr_i  (err_corr_i),
    .err_addr_i  (err_addr_i),
    .err_data_i  (err_data_i),
    .err_ecc_i   (err_ecc_i),
    .busy_o      (busy),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_ecc_o    (wr_ecc_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ok_i    (rsp_ok_i),
    .dropped_o   (dropped_o)
  );

  scrub_hazard #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_hazard (
    .busy_i      (busy),
    .line_addr_i (wr_addr_o),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .hold_o      (req_hold_o)
  );

  scrub_log #(.ADDR_W(ADDR_W)) u_log (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_valid_i (err_valid_i),
    .err_src_i   (err_src_i),
    .err_corr_i  (err_corr_i),
    .err_addr_i  (err_addr_i),
    .busy_i      (busy),
    .log_valid_o (log_valid_o),
    .log_addr_o  (log_addr_o),
    .log_src_o   (log_src_o),
    .log_corr_o  (log_corr_o),
    .log_ovf_o   (log_ovf_o)
  );
endmodule

// File: rtl/scrub_seq_chk.sv
module scrub_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_valid_i,
  input logic              req_valid_i,
  input logic              req_hold_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              rsp_valid_i,
  input logic              rsp_ok_i,
  input logic              log_valid_o,
  input logic              log_corr_o,
  input logic              log_ovf_o,
  input logic              dropped_o
);
  assert_log_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_i |=> log_valid_o);
  assert_log_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_valid_i |=> !log_valid_o);
  assert_cmd_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)));
  assert_ovf_corr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_ovf_o |-> (log_valid_o && log_corr_o));
  assert_hold_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_hold_o |-> req_valid_i);
  assert_drop_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dropped_o) |-> $past(rsp_valid_i && !rsp_ok_i));
  assert_drop_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dropped_o |=> !dropped_o);
endmodule

bind scrub_seq scrub_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_valid_i (err_valid_i),
  .req_valid_i (req_valid_i),
  .req_hold_o  (req_hold_o),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_o   (wr_addr_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_ok_i    (rsp_ok_i),
  .log_valid_o (log_valid_o),
  .log_corr_o  (log_corr_o),
  .log_ovf_o   (log_ovf_o),
  .dropped_o   (dropped_o)
);

// File: tb/scrub_seq_tb_top.sv
`timescale 1ns/1ps
module scrub_seq_tb_top;
  localparam int AW = 16, DW = 256, EW = 32, TW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_enh = 0; logic [TW-1:0] bad_th = 0;
  logic err_valid = 0, err_src = 0, err_corr = 0;
  logic [AW-1:0] err_addr = 0; logic [DW-1:0] err_data = 0; logic [EW-1:0] err_ecc = 0;
  logic req_valid = 0; logic [AW-1:0] req_addr = 0; logic req_hold;
  logic wr_valid, wr_ready = 0; logic [AW-1:0] wr_addr; logic [DW-1:0] wr_data; logic [EW-1:0] wr_ecc;
  logic rsp_valid = 0, rsp_ok = 0;
  logic log_valid, log_src, log_corr, log_ovf, dropped; logic [AW-1:0] log_addr;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  scrub_seq #(.ADDR_W(AW), .DATA_W(DW), .ECC_W(EW), .TH_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_enh_i(mode_enh), .bad_th_i(bad_th),
    .err_valid_i(err_valid), .err_src_i(err_src), .err_corr_i(err_corr),
    .err_addr_i(err_addr), .err_data_i(err_data), .err_ecc_i(err_ecc),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_hold_o(req_hold),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_ecc_o(wr_ecc), .rsp_valid_i(rsp_valid), .rsp_ok_i(rsp_ok),
    .log_valid_o(log_valid), .log_addr_o(log_addr), .log_src_o(log_src),
    .log_corr_o(log_corr), .log_ovf_o(log_ovf), .dropped_o(dropped));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // hold probe: same line when same=1, else a neighbouring line
  task automatic probe(input logic [AW-1:0] base, input bit same, input logic exp, input string req);
    req_valid = 1;
    req_addr  = same ? (base ^ 16'h0013) : (base ^ 16'h0020);
    #0.5;
    chk(req, req_hold, exp);
    req_valid = 0;
  endtask

  task automatic report(input logic [AW-1:0] a, input bit src, input bit corr, input int seed);
    err_valid = 1; err_src = src; err_corr = corr; err_addr = a;
    err_data = {8{32'hA5000000 + seed[31:0]}}; err_ecc = 32'hC0DE0000 + seed[31:0];
    step();
    err_valid = 0;
    chk("R2 log_valid", log_valid, 1);
    chk("R2 log_addr", log_addr, a);
    chk("R2 log_src", log_src, src);
    chk("R2 log_corr", log_corr, corr);
  endtask

  // pat 0 = pass, 1 = fail then pass, 2 = fail twice
  task automatic run_scrub(input bit menh, input logic [TW-1:0] th, input int pat,
                           input bit src, input logic [AW-1:0] a, input int seed);
    bit enh = menh && (th != 0);
    int exp_writes = (enh && pat != 0) ? 2 : 1;
    bit exp_drop = enh && (pat == 2);
    int writes = 0;
    logic [DW-1:0] d = {8{32'hA5000000 + seed[31:0]}};
    mode_enh = menh; bad_th = th;
    probe(a, 1, 0, "R6 idle no hold");
    report(a, src, 1'b1, seed);
    chk("R5 no ovf when idle", log_ovf, 0);
    for (int att = 0; att < exp_writes; att++) begin
      chk("R3 wr_valid", wr_valid, 1);
      chk("R3 wr_addr aligned", wr_addr, {a[AW-1:5], 5'd0});
      chk("R3 wr_data", (wr_data == d), 1);
      chk("R3 wr_ecc", wr_ecc, 32'hC0DE0000 + seed[31:0]);
      probe(a, 1, 1, "R6 hold same line");
      probe(a, 0, 0, "R6 other line passes");
      step();
      chk("R3 wr_valid stays until ready", wr_valid, 1);
      wr_ready = 1;
      step();
      wr_ready = 0; writes++;
      chk("R3 wr_valid drops after ready", wr_valid, 0);
      probe(a, 1, 1, "R6 hold during wait");
      rsp_valid = 1;
      rsp_ok = (pat == 0) || (pat == 1 && att == 1);
      step();
      rsp_valid = 0;
      if (att + 1 < exp_writes) chk("R8 replay issued", wr_valid, 1);
    end
    probe(a, 1, 0, enh ? "R9 R8 hold released" : "R7 hold released");
    chk(enh ? "R9 dropped pulse" : "R7 no drop", dropped, exp_drop);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(enh ? "R9 no further write" : "R7 single write", wr_valid, 0);
      chk("R9 drop one cycle", dropped, 0);
    end
    chk(enh ? "R8 write count" : "R7 write count", writes, exp_writes);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 log_valid", log_valid, 0);
    chk("R1 log_ovf", log_ovf, 0);
    chk("R1 dropped", dropped, 0);
    probe(16'h0040, 1, 0, "R1 hold");
    rst_n = 1;
    step();
    // sweep modes x response patterns x sources
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++) begin
          int seed = m * 6 + p * 2 + s;
          run_scrub(m != 0, (m == 2) ? 4'd3 : 4'd0, p, s[0],
                    16'h1000 + 16'(seed * 16'h0047), seed);
        end
    // mode bit set but threshold zero acts as normal
    run_scrub(1'b1, 4'd0, 2, 1'b0, 16'h2345, 40);
    // uncorrectable: log only
    report(16'h3333, 1'b1, 1'b0, 50);
    chk("R4 ovf clear", log_ovf, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R4 no write", wr_valid, 0);
      step();
    end
    chk("R2 quiet log", log_valid, 0);
    // overflow: second correctable report while busy
    mode_enh = 0; bad_th = 0;
    report(16'h4400, 1'b0, 1'b1, 60);
    chk("R3 busy write", wr_valid, 1);
    report(16'h5500, 1'b1, 1'b1, 61);
    chk("R5 ovf flagged", log_ovf, 1);
    wr_ready = 1; step(); wr_ready = 0;
    probe(16'h5500, 1, 0, "R5 overflow line not held");
    rsp_valid = 1; rsp_ok = 1; step(); rsp_valid = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R5 no extra write", wr_valid, 0);
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule